// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining the branch's own address with the outcomes of the most recent branches seen anywhere in the program. It keeps a short global outcome history and a table of saturating counters. Each branch address owns one counter for every possible history pattern, so the same branch can learn a different direction for each recent-outcome context. The predicted direction is the top bit of the selected counter.

A front end drives the fetch address on the lookup port and gets back a combinational taken/not-taken guess together with the history value used to form it. The caller carries that history alongside the branch. When the branch resolves, the caller returns the branch address, the real outcome and the carried history on the update port. The update trains the counter that the lookup used and shifts the real outcome into the global history.

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (binary 01 for 2-bit counters), so every lookup predicts not taken, and the global history reads all zeros.
- R2: The lookup output is 1 (taken) exactly when the most significant bit of the selected counter is 1. It is combinational from the lookup address and the current history.
- R3: The selected counter is the table entry addressed by {history, address[IDX_W+1:2]}, with the history in the upper bits. Address bits [1:0] and all bits above IDX_W+1 have no effect on the selection.
- R4: An update whose outcome is taken raises the addressed counter by one and holds it at the maximum value (all ones).
- R5: An update whose outcome is not taken lowers the addressed counter by one and holds it at zero.
- R6: Each valid update shifts the history left by one and places the resolved outcome in bit 0 (1 = taken). The oldest outcome is dropped.
- R7: With 2-bit counters, a branch held at strongly taken still predicts taken after one not-taken update. It predicts not taken only after a second consecutive one.
- R8: When a lookup and an update happen in the same cycle, the lookup returns the value from before the update.
- R9: While the update valid input is low, neither the counters nor the history change, whatever the other update inputs carry.
- R10: The update trains the counter chosen by the history returned on the update port, not the live history. For one address, counters under different histories are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lkPc | input | PC_W | Address of the branch being looked up |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| lkHist | output | HIST_W | Global history used by this lookup |
| updValid | input | 1 | Update strobe |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| updHist | input | HIST_W | History that was returned at lookup of this branch |

## Verification
The lookup result and the history output are combinational from registered state. The bench therefore reads them one nanosecond after it drives a new address on the falling edge, before the next rising edge. An update takes effect at the first rising edge after it is driven, so its result on the counters and the history becomes visible at the falling edge that follows. The bench checks there, or at any later lookup. For the same-cycle case, the bench samples the lookup while the update is still pending. It then samples again after the edge to see the trained value.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic inc;    // raise addressed counter
    logic dec;    // lower addressed counter
    logic shift;  // shift outcome into history
  } bpStrobe_t;

endpackage

// File: rtl/corr_bp_ctrl.sv
module corr_bp_ctrl
  import corr_bp_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CTR_W-1:0] updCtr,
  output bpStrobe_t        strb
);

  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic atTop;
  logic atBottom;

  always_comb begin
    atTop      = (updCtr == CTR_MAX);
    atBottom   = (updCtr == CTR_MIN);
    strb.inc   = updValid && updTaken && !atTop;
    strb.dec   = updValid && !updTaken && !atBottom;
    strb.shift = updValid;
  end

endmodule

// File: rtl/corr_bp_datapath.sv
module corr_bp_datapath
  import corr_bp_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strb,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [HIST_W-1:0] updHist,
  output logic              lkTaken,
  output logic [HIST_W-1:0] lkHist,
  output logic [CTR_W-1:0]  updCtr
);

  localparam int TBL_W = HIST_W + IDX_W;
  localparam int DEPTH = 1 << TBL_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] WEAK_NT  = CTR_MAX >> 1;
  localparam logic [CTR_W-1:0] CTR_ONE  = {{(CTR_W-1){1'b0}}, 1'b1};

  logic [CTR_W-1:0]  tableQ [DEPTH];
  logic [HIST_W-1:0] histQ;
  logic [HIST_W-1:0] histNext;
  logic [TBL_W-1:0]  lkFull;
  logic [TBL_W-1:0]  updFull;
  logic [CTR_W-1:0]  lkCtr;

  // Table address: history above address bits
  always_comb begin
    lkFull  = {histQ, lkIdx};
    updFull = {updHist, updIdx};
    lkCtr   = tableQ[lkFull];
    updCtr  = tableQ[updFull];
    lkTaken = lkCtr[CTR_W-1];
    lkHist  = histQ;
  end

  generate
    if (HIST_W > 1) begin : g_histWide
      always_comb histNext = {histQ[HIST_W-2:0], updTaken};
    end else begin : g_histOne
      always_comb histNext = updTaken;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tableQ[i] <= WEAK_NT;
      histQ <= '0;
    end else begin
      if (strb.inc)      tableQ[updFull] <= updCtr + CTR_ONE;
      else if (strb.dec) tableQ[updFull] <= updCtr - CTR_ONE;
      if (strb.shift)    histQ <= histNext;
    end
  end

  AST_CTR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc |=> tableQ[$past(updFull)] == CTR_W'($past(updCtr) + CTR_ONE)); // R4
  AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && updCtr == CTR_MAX) |=> tableQ[$past(updFull)] == CTR_MAX); // R4
  AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && updCtr == '0) |=> tableQ[$past(updFull)] == '0); // R5
  AST_HIST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> histQ[0] == $past(updTaken)); // R6
  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ)); // R9

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor
  import corr_bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lkPc,
  output logic              lkTaken,
  output logic [HIST_W-1:0] lkHist,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updHist
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  bpStrobe_t        strb;
  logic [CTR_W-1:0] updCtr;
  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] updIdx;

  assign lkIdx  = lkPc[IDX_MSB:IDX_LSB];
  assign updIdx = updPc[IDX_MSB:IDX_LSB];

  corr_bp_ctrl #(.CTR_W(CTR_W)) u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updCtr   (updCtr),
    .strb     (strb)
  );

  corr_bp_datapath #(.HIST_W(HIST_W), .CTR_W(CTR_W), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .updValid (updValid),
    .updTaken (updTaken),
    .lkIdx    (lkIdx),
    .updIdx   (updIdx),
    .updHist  (updHist),
    .lkTaken  (lkTaken),
    .lkHist   (lkHist),
    .updCtr   (updCtr)
  );

endmodule

// File: tb/corr_predictor_tb.sv
module corr_predictor_tb;

  localparam int PC_W = 32;
  localparam int HW   = 2;
  localparam int NV   = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [PC_W-1:0] lkPc;
  logic          lkTaken;
  logic [HW-1:0] lkHist;
  logic          updValid;
  logic [PC_W-1:0] updPc;
  logic          updTaken;
  logic [HW-1:0] updHist;

  int total = 0;
  int bad   = 0;

  // reference state
  int          mCtr [64];
  logic [1:0]  mHist;

  always #5 clk = ~clk;

  corr_predictor u_dut (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkTaken(lkTaken), .lkHist(lkHist),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updHist(updHist)
  );

  // {valid, updPc, taken, updHist, lkPc}
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 32'h40,   1'b1, 2'b00, 32'h40},
    {1'b1, 32'h40,   1'b1, 2'b01, 32'h44},
    {1'b1, 32'h44,   1'b0, 2'b11, 32'h40},
    {1'b0, 32'h48,   1'b1, 2'b10, 32'h48},
    {1'b1, 32'h48,   1'b1, 2'b10, 32'h48},
    {1'b1, 32'h48,   1'b1, 2'b01, 32'h48},
    {1'b1, 32'h7C,   1'b0, 2'b11, 32'h7C},
    {1'b1, 32'h7C,   1'b0, 2'b10, 32'h40},
    {1'b1, 32'h40,   1'b1, 2'b00, 32'h40},
    {1'b1, 32'h40,   1'b1, 2'b01, 32'h40},
    {1'b1, 32'h40,   1'b1, 2'b11, 32'h40},
    {1'b1, 32'h40,   1'b1, 2'b11, 32'h42},
    {1'b1, 32'h1040, 1'b0, 2'b11, 32'h40},
    {1'b1, 32'h40,   1'b0, 2'b10, 32'h40},
    {1'b0, 32'h40,   1'b0, 2'b00, 32'h40},
    {1'b1, 32'h4C,   1'b1, 2'b00, 32'h4C}
  };

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic modelPred(logic [PC_W-1:0] pc);
    return mCtr[{mHist, pc[5:2]}] >= 2;
  endfunction

  task automatic modelUpd(logic [PC_W-1:0] pc, logic t, logic [1:0] h);
    int i;
    i = {h, pc[5:2]};
    if (t && mCtr[i] < 3) mCtr[i]++;
    if (!t && mCtr[i] > 0) mCtr[i]--;
    mHist = {mHist[0], t};
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; updValid = 1'b0; updPc = '0; updTaken = 1'b0; updHist = '0; lkPc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 64; i++) mCtr[i] = 1;
    mHist = 2'b00;
  endtask

  task automatic probe(logic [PC_W-1:0] pc, logic exp, string tag);
    @(negedge clk);
    updValid = 1'b0;
    lkPc = pc;
    #1 check(tag, {3'b0, lkTaken}, {3'b0, exp});
  endtask

  task automatic probeHist(logic [1:0] exp, string tag);
    @(negedge clk);
    updValid = 1'b0;
    #1 check(tag, {2'b0, lkHist}, {2'b0, exp});
  endtask

  // update; lookup same address in the same cycle
  task automatic doUpd(logic [PC_W-1:0] pc, logic t, logic [1:0] h,
                       bit chkPre, logic expPre, string tag);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = t; updHist = h; lkPc = pc;
    #1 if (chkPre) check(tag, {3'b0, lkTaken}, {3'b0, expPre});
    @(posedge clk);
    modelUpd(pc, t, h);
  endtask

  // two not-taken updates on index 15 bring the history to 00
  task automatic clearHist();
    doUpd(32'h3C, 1'b0, 2'b00, 0, 1'b0, "");
    doUpd(32'h3C, 1'b0, 2'b00, 0, 1'b0, "");
  endtask

  initial begin : watchdog
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1: every address predicts not taken, history zero
    for (int i = 0; i < 16; i++) probe(32'(i) << 2, 1'b0, "R1 reset prediction");
    probeHist(2'b00, "R1 reset history");

    // train {00,idx0} to strongly taken
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    probeHist(2'b01, "R6 history after one taken");
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    probeHist(2'b11, "R6 history after two taken");
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    // R10: live history 11 selects an untrained counter
    probe(32'h40, 1'b0, "R10 other history independent");
    clearHist();
    probeHist(2'b00, "R6 history after two not taken");
    probe(32'h40, 1'b1, "R2 trained counter predicts taken");
    probe(32'h43, 1'b1, "R3 low address bits ignored");
    probe(32'h1040, 1'b1, "R3 high address bits ignored");
    probe(32'h3C, 1'b0, "R3 other index not taken");

    // R9: idle update with not-taken outcome must do nothing
    @(negedge clk);
    updValid = 1'b0; updPc = 32'h40; updTaken = 1'b0; updHist = 2'b00;
    @(posedge clk);
    probe(32'h40, 1'b1, "R9 idle update left counter");
    probeHist(2'b00, "R9 idle update left history");

    // R7 and R8: first miss keeps taken, second flips
    doUpd(32'h40, 1'b0, 2'b00, 1, 1'b1, "R8 same-cycle lookup sees old value");
    probe(32'h40, 1'b1, "R7 one miss still taken");
    doUpd(32'h40, 1'b0, 2'b00, 1, 1'b1, "R8 same-cycle lookup before flip");
    probe(32'h40, 1'b0, "R7 two misses predict not taken");

    // R5: saturate at zero
    doUpd(32'h40, 1'b0, 2'b00, 0, 1'b0, "");
    doUpd(32'h40, 1'b0, 2'b00, 0, 1'b0, "");
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    clearHist();
    probe(32'h40, 1'b0, "R5 one taken after floor");
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    clearHist();
    probe(32'h40, 1'b1, "R5 two taken after floor");

    // R4: saturate at max
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    doUpd(32'h40, 1'b1, 2'b00, 0, 1'b0, "");
    doUpd(32'h40, 1'b0, 2'b00, 0, 1'b0, "");
    clearHist();
    probe(32'h40, 1'b1, "R4 ceiling held");

    // table walk against reference model
    doReset();
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      updValid = VEC[v][67];
      updPc    = VEC[v][66:35];
      updTaken = VEC[v][34];
      updHist  = VEC[v][33:32];
      lkPc     = VEC[v][31:0];
      #1;
      check("R2 R3 R8 vector prediction", {3'b0, lkTaken}, {3'b0, modelPred(lkPc)});
      check("R6 R9 vector history", {2'b0, lkHist}, {2'b0, mHist});
      @(posedge clk);
      if (VEC[v][67]) modelUpd(VEC[v][66:35], VEC[v][34], VEC[v][33:32]);
    end
    probeHist(mHist, "R6 final history");
    for (int i = 0; i < 16; i++)
      probe(32'(i) << 2, modelPred(32'(i) << 2), "R10 final table");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule